// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block holds a 64-bit time of day, split into a 32-bit seconds field and a 32-bit nanoseconds field. It advances that time from one reference clock. It never advances once per clock edge. A 32-bit phase accumulator adds a software-chosen addend on every reference cycle. Each carry out of the accumulator is one "tick", and each tick adds a programmable nanosecond increment to the time. The addend sets the ratio between the tick rate and the reference rate. A servo can therefore trim the frequency smoothly without stepping the time.

Software can also move the time at once. It can load a new time outright, or add or subtract a signed offset (a coarse step). All of these values arrive through one narrow register-write port. A snapshot strobe copies the current time into a timestamp output, and a valid flag follows one cycle later.

Top module: `ptp_systime`

## Requirements
- R1: After reset, the time, the timestamp and the timestamp-valid flag are all zero, and the active addend and increment are zero, so the time does not move.
- R2: A write with `wr_sel` = 0 sets the pending seconds value, and `wr_sel` = 1 sets the pending nanoseconds value. A cycle with `init_stb` high copies both pending values into the time at that clock edge.
- R3: A cycle with `coarse_stb` high and `coarse_sub` low adds the pending pair to the time at that edge. A nanoseconds sum of 10^9 or more is reduced by 10^9 and carries one into the seconds.
- R4: With `coarse_sub` high, the coarse step subtracts the pending pair instead. A nanoseconds borrow adds 10^9 and takes one from the seconds, and the seconds wrap modulo 2^32.
- R5: On every cycle the accumulator adds the active addend, modulo 2^32. The time changes only on a cycle whose sum carries out, so an active addend of zero freezes the time and an addend of 2^31 ticks on every second cycle.
- R6: A write with `wr_sel` = 3 sets the increment. Each tick adds the increment to the nanoseconds, wrapping past 10^9 into the seconds exactly as in R3.
- R7: A write with `wr_sel` = 2 only stages an addend. The rate is unchanged until a cycle with `addend_stb` high makes the staged value active. The accumulator keeps its residue across that change.
- R8: When several updates fall in one cycle, a load beats a coarse step, and a coarse step beats a tick. A tick that coincides with a load or a coarse step is lost.
- R9: At the edge where `snap_stb` is high, the timestamp takes the time shown just before that edge, and `ts_valid` drops. `ts_valid` rises one cycle later.
- R10: As long as the pending nanoseconds and the increment written by software stay below 10^9, the nanoseconds output stays below 10^9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 pending seconds, 1 pending nanoseconds, 2 staged addend, 3 increment |
| wr_data | input | 32 | Write data |
| init_stb | input | 1 | Load the pending pair into the time |
| coarse_stb | input | 1 | Apply the pending pair as a coarse step |
| coarse_sub | input | 1 | Coarse step subtracts (1) or adds (0) |
| addend_stb | input | 1 | Make the staged addend active |
| snap_stb | input | 1 | Capture the current time |
| time_sec | output | 32 | Current seconds |
| time_nsec | output | 32 | Current nanoseconds |
| ts_sec | output | 32 | Captured seconds |
| ts_nsec | output | 32 | Captured nanoseconds |
| ts_valid | output | 1 | Captured time is valid |

## Verification
The nanoseconds-range property and the tick property both assume that software never writes a pending nanoseconds value or an increment of 10^9 or more. No stimulus in the bench ever writes such a value. The tick property also assumes a non-zero increment, and it is only armed under that condition. The bench controls when ticks happen by choosing addend values that are powers of two and by counting edges from a known accumulator residue. This lets every coincidence in the priority test land on a known cycle.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;

    typedef enum logic [1:0] {
        SEL_UPD_SEC  = 2'd0,
        SEL_UPD_NSEC = 2'd1,
        SEL_ADDEND   = 2'd2,
        SEL_INCR     = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_COARSE = 2'd2,
        OP_TICK   = 2'd3
    } time_op_e;

endpackage

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stage_we,
    input  logic [ACC_W-1:0] stage_val,
    input  logic             commit,
    output logic             tick,
    output logic [ACC_W-1:0] addend_o
);

    typedef struct packed {
        logic [ACC_W-1:0] stage;
        logic [ACC_W-1:0] addend;
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        st_d   = st_q;
        sum    = {1'b0, st_q.acc} + {1'b0, st_q.addend};
        st_d.acc = sum[ACC_W-1:0];
        if (stage_we) st_d.stage  = stage_val;
        if (commit)   st_d.addend = st_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick     = sum[ACC_W];
    assign addend_o = st_q.addend;

endmodule

// File: rtl/ptp_time_next.sv
module ptp_time_next
    import ptp_systime_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int NSEC_W     = 32,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  time_op_e          op,
    input  logic              sub,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [NSEC_W-1:0] cur_nsec,
    input  logic [SEC_W-1:0]  upd_sec,
    input  logic [NSEC_W-1:0] upd_nsec,
    input  logic [NSEC_W-1:0] incr,
    output logic [SEC_W-1:0]  nxt_sec,
    output logic [NSEC_W-1:0] nxt_nsec
);

    localparam logic [NSEC_W:0] NS_WIDE = (NSEC_W+1)'(NS_PER_SEC);

    logic [NSEC_W-1:0] rhs;
    logic [NSEC_W:0]   sum;
    logic [NSEC_W:0]   borrowed;
    logic              wrap;

    always_comb begin
        rhs      = (op == OP_TICK) ? incr : upd_nsec;
        sum      = {1'b0, cur_nsec} + {1'b0, rhs};
        wrap     = (sum >= NS_WIDE);
        borrowed = {1'b0, cur_nsec} + NS_WIDE - {1'b0, upd_nsec};
        nxt_sec  = cur_sec;
        nxt_nsec = cur_nsec;
        unique case (op)
            OP_LOAD: begin
                nxt_sec  = upd_sec;
                nxt_nsec = upd_nsec;
            end
            OP_TICK: begin
                nxt_nsec = wrap ? NSEC_W'(sum - NS_WIDE) : sum[NSEC_W-1:0];
                nxt_sec  = cur_sec + (wrap ? SEC_W'(1) : SEC_W'(0));
            end
            OP_COARSE: begin
                if (!sub) begin
                    nxt_nsec = wrap ? NSEC_W'(sum - NS_WIDE) : sum[NSEC_W-1:0];
                    nxt_sec  = cur_sec + upd_sec + (wrap ? SEC_W'(1) : SEC_W'(0));
                end else if (cur_nsec >= upd_nsec) begin
                    nxt_nsec = cur_nsec - upd_nsec;
                    nxt_sec  = cur_sec - upd_sec;
                end else begin
                    nxt_nsec = borrowed[NSEC_W-1:0];
                    nxt_sec  = cur_sec - upd_sec - SEC_W'(1);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
    import ptp_systime_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SEC_W      = 32,
    parameter int NSEC_W     = 32,
    parameter int ACC_W      = 32,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              init_stb,
    input  logic              coarse_stb,
    input  logic              coarse_sub,
    input  logic              addend_stb,
    input  logic              snap_stb,
    output logic [SEC_W-1:0]  time_sec,
    output logic [NSEC_W-1:0] time_nsec,
    output logic [SEC_W-1:0]  ts_sec,
    output logic [NSEC_W-1:0] ts_nsec,
    output logic              ts_valid
);

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NSEC_W-1:0] nsec;
        logic [SEC_W-1:0]  upd_sec;
        logic [NSEC_W-1:0] upd_nsec;
        logic [NSEC_W-1:0] incr;
        logic [SEC_W-1:0]  ts_sec;
        logic [NSEC_W-1:0] ts_nsec;
        logic              ts_valid;
        logic              snap_pend;
    } tod_state_t;

    tod_state_t r_d, r_q;

    wr_sel_e           sel;
    time_op_e          op;
    logic              tick;
    logic [ACC_W-1:0]  addend_cur;
    logic [SEC_W-1:0]  nxt_sec;
    logic [NSEC_W-1:0] nxt_nsec;

    assign sel = wr_sel_e'(wr_sel);

    ptp_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .stage_we  (wr_en && sel == SEL_ADDEND),
        .stage_val (ACC_W'(wr_data)),
        .commit    (addend_stb),
        .tick      (tick),
        .addend_o  (addend_cur)
    );

    always_comb begin
        if (init_stb)        op = OP_LOAD;
        else if (coarse_stb) op = OP_COARSE;
        else if (tick)       op = OP_TICK;
        else                 op = OP_HOLD;
    end

    ptp_time_next #(
        .SEC_W      (SEC_W),
        .NSEC_W     (NSEC_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_next (
        .op       (op),
        .sub      (coarse_sub),
        .cur_sec  (r_q.sec),
        .cur_nsec (r_q.nsec),
        .upd_sec  (r_q.upd_sec),
        .upd_nsec (r_q.upd_nsec),
        .incr     (r_q.incr),
        .nxt_sec  (nxt_sec),
        .nxt_nsec (nxt_nsec)
    );

    always_comb begin
        r_d           = r_q;
        r_d.sec       = nxt_sec;
        r_d.nsec      = nxt_nsec;
        r_d.snap_pend = snap_stb;
        if (wr_en) begin
            unique case (sel)
                SEL_UPD_SEC:  r_d.upd_sec  = SEC_W'(wr_data);
                SEL_UPD_NSEC: r_d.upd_nsec = NSEC_W'(wr_data);
                SEL_INCR:     r_d.incr     = NSEC_W'(wr_data);
                default: ;
            endcase
        end
        if (snap_stb) begin
            r_d.ts_sec   = r_q.sec;
            r_d.ts_nsec  = r_q.nsec;
            r_d.ts_valid = 1'b0;
        end else if (r_q.snap_pend) begin
            r_d.ts_valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign time_sec  = r_q.sec;
    assign time_nsec = r_q.nsec;
    assign ts_sec    = r_q.ts_sec;
    assign ts_nsec   = r_q.ts_nsec;
    assign ts_valid  = r_q.ts_valid;

endmodule

// File: rtl/ptp_systime_chk.sv
module ptp_systime_chk #(
    parameter int SEC_W      = 32,
    parameter int NSEC_W     = 32,
    parameter int ACC_W      = 32,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_stb,
    input logic              coarse_stb,
    input logic              addend_stb,
    input logic              snap_stb,
    input logic              tick,
    input logic [ACC_W-1:0]  addend,
    input logic [SEC_W-1:0]  upd_sec,
    input logic [NSEC_W-1:0] upd_nsec,
    input logic [NSEC_W-1:0] incr,
    input logic [SEC_W-1:0]  time_sec,
    input logic [NSEC_W-1:0] time_nsec,
    input logic [SEC_W-1:0]  ts_sec,
    input logic [NSEC_W-1:0] ts_nsec,
    input logic              ts_valid
);

    localparam logic [NSEC_W-1:0] NS_LIM = NSEC_W'(NS_PER_SEC);

    // R10: the nanoseconds field never reaches one second
    assert_nsec_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        time_nsec < NS_LIM);

    // R2 and R8: a load wins over anything else in its cycle
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |=> (time_sec == $past(upd_sec)) && (time_nsec == $past(upd_nsec)));

    // R5: without a carry or a software update the time is frozen
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !init_stb && !coarse_stb) |=> ($stable(time_sec) && $stable(time_nsec)));

    // R6: a lone tick with a non-zero increment moves the nanoseconds
    assert_tick_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !init_stb && !coarse_stb && incr != '0) |=> (time_nsec != $past(time_nsec)));

    // R7: the active addend changes only on its strobe
    assert_addend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !addend_stb |=> $stable(addend));

    // R9: capture takes the pre-edge time and clears the flag
    assert_snap_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stb |=> (ts_sec == $past(time_sec)) && (ts_nsec == $past(time_nsec)) && !ts_valid);

    // R9: the flag rises only one cycle after a capture
    assert_valid_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts_valid) |-> $past(snap_stb, 2));

endmodule

bind ptp_systime ptp_systime_chk #(
    .SEC_W      (SEC_W),
    .NSEC_W     (NSEC_W),
    .ACC_W      (ACC_W),
    .NS_PER_SEC (NS_PER_SEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_stb   (init_stb),
    .coarse_stb (coarse_stb),
    .addend_stb (addend_stb),
    .snap_stb   (snap_stb),
    .tick       (tick),
    .addend     (addend_cur),
    .upd_sec    (r_q.upd_sec),
    .upd_nsec   (r_q.upd_nsec),
    .incr       (r_q.incr),
    .time_sec   (time_sec),
    .time_nsec  (time_nsec),
    .ts_sec     (ts_sec),
    .ts_nsec    (ts_nsec),
    .ts_valid   (ts_valid)
);

// File: tb/ptp_systime_test.sv
module ptp_systime_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        init_stb = 1'b0, coarse_stb = 1'b0, coarse_sub = 1'b0;
    logic        addend_stb = 1'b0, snap_stb = 1'b0;
    logic [31:0] time_sec, time_nsec, ts_sec, ts_nsec;
    logic        ts_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_systime uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .init_stb(init_stb), .coarse_stb(coarse_stb), .coarse_sub(coarse_sub),
        .addend_stb(addend_stb), .snap_stb(snap_stb),
        .time_sec(time_sec), .time_nsec(time_nsec),
        .ts_sec(ts_sec), .ts_nsec(ts_nsec), .ts_valid(ts_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_time(input string req, input logic [31:0] s, input logic [31:0] ns);
        check({req, " sec"}, {32'd0, time_sec}, {32'd0, s});
        check({req, " nsec"}, {32'd0, time_nsec}, {32'd0, ns});
    endtask

    // one clock edge; inputs change and outputs are sampled at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; init_stb = 1'b0; coarse_stb = 1'b0; coarse_sub = 1'b0;
        addend_stb = 1'b0; snap_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
    endtask

    task automatic t_reset();
        check_time("R1 reset", 32'd0, 32'd0);
        check("R1 ts_valid", {63'd0, ts_valid}, 64'd0);
        check("R1 ts_sec", {32'd0, ts_sec}, 64'd0);
        idle(5);
        check_time("R1 R5 frozen with zero addend", 32'd0, 32'd0);
    endtask

    task automatic t_init();
        wr(2'd0, 32'd100);
        wr(2'd1, 32'd999_999_950);
        check_time("R2 pending write alone", 32'd0, 32'd0);
        init_stb = 1'b1;
        step();
        check_time("R2 load", 32'd100, 32'd999_999_950);
    endtask

    task automatic t_ticks();
        wr(2'd3, 32'd20);
        wr(2'd2, 32'h8000_0000);
        addend_stb = 1'b1;
        step();
        idle(10);
        check_time("R5 R6 R10 half-rate ticks with wrap", 32'd101, 32'd50);
        wr(2'd2, 32'h4000_0000);
        idle(3);
        check_time("R7 staged addend ignored", 32'd101, 32'd90);
        addend_stb = 1'b1;
        step();
        idle(2);
        check_time("R7 residue kept on commit", 32'd101, 32'd110);
        wr(2'd2, 32'd0);
        addend_stb = 1'b1;
        step();
        idle(3);
        check_time("R5 zero addend stops time", 32'd101, 32'd110);
    endtask

    task automatic t_coarse();
        wr(2'd0, 32'd5);
        wr(2'd1, 32'd999_999_900);
        coarse_stb = 1'b1;
        step();
        check_time("R3 coarse add with carry", 32'd107, 32'd10);
        wr(2'd0, 32'd7);
        wr(2'd1, 32'd20);
        coarse_stb = 1'b1; coarse_sub = 1'b1;
        step();
        check_time("R4 coarse sub with borrow", 32'd99, 32'd999_999_990);
        wr(2'd0, 32'd200);
        wr(2'd1, 32'd0);
        coarse_stb = 1'b1; coarse_sub = 1'b1;
        step();
        check_time("R4 seconds wrap", 32'd4294967195, 32'd999_999_990);
    endtask

    task automatic t_priority();
        // accumulator residue is 2^31 here, so the edge after the commit carries
        wr(2'd0, 32'd1000);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h8000_0000);
        addend_stb = 1'b1;
        step();
        init_stb = 1'b1; coarse_stb = 1'b1;
        step();
        check_time("R8 load beats coarse and tick", 32'd1000, 32'd0);
        step();
        coarse_stb = 1'b1;
        step();
        check_time("R8 coarse beats tick", 32'd2000, 32'd0);
        wr(2'd2, 32'd0);
        addend_stb = 1'b1;
        step();
        check_time("R6 tick after priority", 32'd2000, 32'd20);
    endtask

    task automatic t_snap();
        wr(2'd0, 32'd3000);
        wr(2'd1, 32'd5);
        snap_stb = 1'b1; init_stb = 1'b1;
        step();
        check("R9 ts_sec pre-edge", {32'd0, ts_sec}, 64'd2000);
        check("R9 ts_nsec pre-edge", {32'd0, ts_nsec}, 64'd20);
        check("R9 valid low at capture", {63'd0, ts_valid}, 64'd0);
        check_time("R2 load alongside capture", 32'd3000, 32'd5);
        step();
        check("R9 valid one cycle later", {63'd0, ts_valid}, 64'd1);
        snap_stb = 1'b1;
        step();
        check("R9 second capture clears valid", {63'd0, ts_valid}, 64'd0);
        check("R9 second capture sec", {32'd0, ts_sec}, 64'd3000);
        step();
        check("R9 valid again", {63'd0, ts_valid}, 64'd1);
        check("R9 ts_nsec held", {32'd0, ts_nsec}, 64'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_ticks();
        t_coarse();
        t_priority();
        t_snap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule